// File: doc/BRIEF.md
# Forward-Euler Solver for y'' + 3xy' + 3y = 0

This block integrates the second-order equation y'' + 3·x·y' + 3·y = 0 with the forward Euler method. The equation is treated as a system in x, y and u = y'. It is a scheduled multicycle datapath. One shared multiplier and one shared ALU (add, subtract, signed less-than) do all the work. A control state machine steers operands into these units and routes their results into temporary registers. When idle, the block raises `ready`. A `start` pulse then captures five operands: the start point x, the value y, the slope u, the step dx and the bound a.

Each Euler step computes three values from the old x, u and y: the new x is x + dx, the new u is u − 3·x·u·dx − 3·y·dx, and the new y is y + u·dx. It also evaluates whether the new x is below the bound. All three new values are committed together at the end of the step. Stepping continues while the new x is below a. The step that first reaches or passes a is still committed. The final y then appears on `yOut` together with a one-cycle `done` pulse. The number of committed steps appears on `iterCount`. A `restart` input returns the controller to idle from any state.

Top module: `euler_solver`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `ready` is 1, `done` is 0, `yOut` is 0 and `iterCount` is 0.
- R2: `start` is accepted only at a rising edge where `ready` is 1 and `restart` is 0. `ready` is 0 from the next cycle until the run ends. A `start` pulse given while the block is busy has no effect on that run's result.
- R3: All values are 16-bit two's-complement Q8.8. Each product is the full 32-bit signed product with bits [23:8] kept (an arithmetic right shift by 8, then wraparound). The constant 3 is 0x0300. Sums and differences wrap at 16 bits. Each step computes xn = x + dx, un = u − ((3·x)·u)·dx − (3·y)·dx and yn = y + u·dx, with the products formed in exactly that grouping, all from the old values.
- R4: After each step, a signed comparison xn < a decides the next action: another step if true, the end of the run if false. `iterCount` equals the number of committed steps, and `yOut` is the y after the last committed step.
- R5: When a ≤ x at start and dx ≥ 0, exactly one step is committed, and `yOut` is y + u·dx.
- R6: Each step takes 7 cycles. For N steps, `done` is high in the cycle that starts 7·N rising edges after the edge that accepted `start`.
- R7: `done` is high for exactly one cycle, and `ready` returns to 1 in the next cycle. `yOut` and `iterCount` keep their values until the next accepted `start`. `yOut` changes only in a cycle in which `done` is high.
- R8: When `restart` is 1 at a rising edge, the block is idle in the next cycle (`ready` 1, `done` 0), and the aborted run never raises `done`. `yOut` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to capture operands and begin a run |
| restart | input | 1 | Return to idle from any state |
| xIn | input | 16 | Start point x, Q8.8 |
| yIn | input | 16 | Initial y, Q8.8 |
| uIn | input | 16 | Initial slope y', Q8.8 |
| dxIn | input | 16 | Step size, Q8.8 |
| aIn | input | 16 | Upper bound for x, Q8.8 |
| ready | output | 1 | Idle and able to accept start |
| done | output | 1 | One-cycle strobe marking a valid result |
| yOut | output | 16 | Final y of the last completed run, Q8.8 |
| iterCount | output | 16 | Steps committed in the last run |

## Verification
Runs with small positive steps and many iterations show whether the 3·x·u·dx and 3·y·dx terms are grouped and rounded as specified, since the error from each product builds up over the steps. A start point below zero checks that the bound test is a signed comparison. Large y and u values force wraparound in products and sums, which separates keeping bits [23:8] from saturating or keeping other bits. A bound at or below the start point shows whether the final step is still committed. A start pulse during a run, and a restart partway through a run, show that busy-time inputs are ignored and that aborting a run leaves the last result untouched.

// File: rtl/euler_pkg.sv
package euler_pkg;

  typedef enum logic [2:0] {
    MS_NONE,
    MS_3X,
    MS_P1U,
    MS_P1DX,
    MS_3Y,
    MS_P2DX,
    MS_UDX
  } mulStep_e;

  typedef enum logic [2:0] {
    AS_NONE,
    AS_X1,
    AS_CMP,
    AS_USUB1,
    AS_USUB2,
    AS_Y1
  } aluStep_e;

  typedef enum logic [1:0] {
    ALU_ADD,
    ALU_SUB,
    ALU_LT
  } aluOp_e;

  typedef struct packed {
    logic     load;
    mulStep_e mulStep;
    aluStep_e aluStep;
    logic     commit;
    logic     latchOut;
  } ctrlStrobes_t;

endpackage

// File: rtl/euler_mul.sv
module euler_mul #(
  parameter int WIDTH = 16,
  parameter int FRAC  = 8
) (
  input  logic signed [WIDTH-1:0] opA,
  input  logic signed [WIDTH-1:0] opB,
  output logic signed [WIDTH-1:0] result
);
  localparam int PW = 2 * WIDTH;

  logic signed [PW-1:0] fullProd;

  always_comb begin
    fullProd = PW'(opA) * PW'(opB);
    result   = fullProd[FRAC+WIDTH-1:FRAC];
  end
endmodule

// File: rtl/euler_alu.sv
module euler_alu
  import euler_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic signed [WIDTH-1:0] opA,
  input  logic signed [WIDTH-1:0] opB,
  input  aluOp_e                  op,
  output logic signed [WIDTH-1:0] result,
  output logic                    isLess
);
  always_comb begin
    isLess = (opA < opB);
    unique case (op)
      ALU_ADD: result = opA + opB;
      ALU_SUB: result = opA - opB;
      ALU_LT:  result = {{(WIDTH-1){1'b0}}, isLess};
      default: result = '0;
    endcase
  end
endmodule

// File: rtl/euler_ctrl.sv
module euler_ctrl
  import euler_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         restart,
  input  logic         contFlag,
  output ctrlStrobes_t strobe,
  output logic         ready,
  output logic         done
);
  typedef enum logic [3:0] {
    ST_READ, ST_S1, ST_S2, ST_S3, ST_S4, ST_S5, ST_S6, ST_S7, ST_WRITE
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_READ;
    else       state <= nextState;
  end

  always_comb begin
    nextState       = state;
    strobe.load     = 1'b0;
    strobe.mulStep  = MS_NONE;
    strobe.aluStep  = AS_NONE;
    strobe.commit   = 1'b0;
    strobe.latchOut = 1'b0;
    unique case (state)
      ST_READ: begin
        if (start) begin
          strobe.load = 1'b1;
          nextState   = ST_S1;
        end
      end
      ST_S1: begin
        strobe.mulStep = MS_3X;
        strobe.aluStep = AS_X1;
        nextState      = ST_S2;
      end
      ST_S2: begin
        strobe.mulStep = MS_P1U;
        strobe.aluStep = AS_CMP;
        nextState      = ST_S3;
      end
      ST_S3: begin
        strobe.mulStep = MS_P1DX;
        nextState      = ST_S4;
      end
      ST_S4: begin
        strobe.mulStep = MS_3Y;
        strobe.aluStep = AS_USUB1;
        nextState      = ST_S5;
      end
      ST_S5: begin
        strobe.mulStep = MS_P2DX;
        nextState      = ST_S6;
      end
      ST_S6: begin
        strobe.mulStep = MS_UDX;
        strobe.aluStep = AS_USUB2;
        nextState      = ST_S7;
      end
      ST_S7: begin
        strobe.aluStep  = AS_Y1;
        strobe.commit   = 1'b1;
        strobe.latchOut = !contFlag;
        nextState       = contFlag ? ST_S1 : ST_WRITE;
      end
      ST_WRITE: nextState = ST_READ;
      default:  nextState = ST_READ;
    endcase
    if (restart) begin
      nextState       = ST_READ;
      strobe.load     = 1'b0;
      strobe.commit   = 1'b0;
      strobe.latchOut = 1'b0;
      strobe.mulStep  = MS_NONE;
      strobe.aluStep  = AS_NONE;
    end
  end

  assign ready = (state == ST_READ);
  assign done  = (state == ST_WRITE);
endmodule

// File: rtl/euler_dp.sv
module euler_dp
  import euler_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int FRAC  = 8,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  ctrlStrobes_t            strobe,
  input  logic signed [WIDTH-1:0] xIn,
  input  logic signed [WIDTH-1:0] yIn,
  input  logic signed [WIDTH-1:0] uIn,
  input  logic signed [WIDTH-1:0] dxIn,
  input  logic signed [WIDTH-1:0] aIn,
  output logic                    contFlag,
  output logic signed [WIDTH-1:0] yOut,
  output logic [CNT_W-1:0]        iterCount
);
  localparam int THREE_INT = 3 << FRAC;
  localparam logic signed [WIDTH-1:0] THREE = THREE_INT[WIDTH-1:0];

  logic signed [WIDTH-1:0] xR, yR, uR, dxR, aR;
  logic signed [WIDTH-1:0] p1R, p2R, p3R, x1R, tR;
  logic                    cR;

  logic signed [WIDTH-1:0] mulA, mulB, mulRes;
  logic signed [WIDTH-1:0] aluA, aluB, aluRes;
  aluOp_e                  aluOp;
  logic                    aluLt;

  euler_mul #(.WIDTH(WIDTH), .FRAC(FRAC)) mul_i (
    .opA(mulA), .opB(mulB), .result(mulRes)
  );

  euler_alu #(.WIDTH(WIDTH)) alu_i (
    .opA(aluA), .opB(aluB), .op(aluOp), .result(aluRes), .isLess(aluLt)
  );

  // multiplier operand steering
  always_comb begin
    mulA = '0;
    mulB = '0;
    unique case (strobe.mulStep)
      MS_3X:   begin mulA = THREE; mulB = xR;  end
      MS_P1U:  begin mulA = p1R;   mulB = uR;  end
      MS_P1DX: begin mulA = p1R;   mulB = dxR; end
      MS_3Y:   begin mulA = THREE; mulB = yR;  end
      MS_P2DX: begin mulA = p2R;   mulB = dxR; end
      MS_UDX:  begin mulA = uR;    mulB = dxR; end
      default: begin mulA = '0;    mulB = '0;  end
    endcase
  end

  // ALU operand steering
  always_comb begin
    aluA  = '0;
    aluB  = '0;
    aluOp = ALU_ADD;
    unique case (strobe.aluStep)
      AS_X1:    begin aluA = xR;  aluB = dxR; aluOp = ALU_ADD; end
      AS_CMP:   begin aluA = x1R; aluB = aR;  aluOp = ALU_LT;  end
      AS_USUB1: begin aluA = uR;  aluB = p1R; aluOp = ALU_SUB; end
      AS_USUB2: begin aluA = tR;  aluB = p2R; aluOp = ALU_SUB; end
      AS_Y1:    begin aluA = yR;  aluB = p3R; aluOp = ALU_ADD; end
      default:  begin aluA = '0;  aluB = '0;  aluOp = ALU_ADD; end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      xR <= '0; yR <= '0; uR <= '0; dxR <= '0; aR <= '0;
      p1R <= '0; p2R <= '0; p3R <= '0; x1R <= '0; tR <= '0;
      cR <= 1'b0;
      yOut <= '0;
      iterCount <= '0;
    end else if (strobe.load) begin
      xR <= xIn; yR <= yIn; uR <= uIn; dxR <= dxIn; aR <= aIn;
      cR <= 1'b0;
      iterCount <= '0;
    end else begin
      unique case (strobe.mulStep)
        MS_3X, MS_P1U, MS_P1DX: p1R <= mulRes;
        MS_3Y, MS_P2DX:         p2R <= mulRes;
        MS_UDX:                 p3R <= mulRes;
        default: ;
      endcase
      unique case (strobe.aluStep)
        AS_X1:              x1R <= aluRes;
        AS_CMP:             cR  <= aluLt;
        AS_USUB1, AS_USUB2: tR  <= aluRes;
        default: ;
      endcase
      if (strobe.commit) begin
        xR <= x1R;
        uR <= tR;
        yR <= aluRes;
        iterCount <= iterCount + 1'b1;
      end
      if (strobe.latchOut) yOut <= aluRes;
    end
  end

  assign contFlag = cR;
endmodule

// File: rtl/euler_solver.sv
module euler_solver
  import euler_pkg::*;
#(
  parameter int WIDTH = 16,
  parameter int FRAC  = 8,
  parameter int CNT_W = 16
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic                    restart,
  input  logic signed [WIDTH-1:0] xIn,
  input  logic signed [WIDTH-1:0] yIn,
  input  logic signed [WIDTH-1:0] uIn,
  input  logic signed [WIDTH-1:0] dxIn,
  input  logic signed [WIDTH-1:0] aIn,
  output logic                    ready,
  output logic                    done,
  output logic signed [WIDTH-1:0] yOut,
  output logic [CNT_W-1:0]        iterCount
);
  ctrlStrobes_t strobe;
  logic         contFlag;

  euler_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .start(start), .restart(restart),
    .contFlag(contFlag), .strobe(strobe), .ready(ready), .done(done)
  );

  euler_dp #(.WIDTH(WIDTH), .FRAC(FRAC), .CNT_W(CNT_W)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .xIn(xIn), .yIn(yIn), .uIn(uIn), .dxIn(dxIn), .aIn(aIn),
    .contFlag(contFlag), .yOut(yOut), .iterCount(iterCount)
  );
endmodule

// File: rtl/euler_solver_chk.sv
module euler_solver_chk #(
  parameter int WIDTH = 16,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic             restart,
  input logic             ready,
  input logic             done,
  input logic [WIDTH-1:0] yOut,
  input logic [CNT_W-1:0] iterCount
);
  // R2: accepted start leaves idle
  p_start_leaves_idle_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ready && start && !restart) |=> (!ready && !done));

  // R7: done is a single-cycle strobe followed by idle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && ready));

  // R7: result changes only together with done
  p_out_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(yOut) |-> done);

  // R4: a finished run has committed at least one step
  p_iter_nonzero_r4: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (iterCount != '0));

  // R8: restart forces idle on the next cycle
  p_restart_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (ready && !done));

  // R2: idle and done never coincide
  p_ready_done_excl_r2: assert property (@(posedge clk) disable iff (!rstN)
    ready |-> !done);
endmodule

bind euler_solver euler_solver_chk #(.WIDTH(WIDTH), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rstN(rstN), .start(start), .restart(restart),
  .ready(ready), .done(done), .yOut(yOut), .iterCount(iterCount)
);

// File: tb/euler_solver_tb_top.sv
module euler_solver_tb_top;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic restart = 1'b0;
  logic signed [15:0] xIn = '0, yIn = '0, uIn = '0, dxIn = '0, aIn = '0;
  logic ready, done;
  logic signed [15:0] yOut;
  logic [15:0] iterCount;

  int checks = 0;
  int fails = 0;

  always #2 clk = ~clk;

  euler_solver dut_i (
    .clk(clk), .rstN(rstN), .start(start), .restart(restart),
    .xIn(xIn), .yIn(yIn), .uIn(uIn), .dxIn(dxIn), .aIn(aIn),
    .ready(ready), .done(done), .yOut(yOut), .iterCount(iterCount)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic signed [15:0] mulq(input logic signed [15:0] a,
                                              input logic signed [15:0] b);
    logic signed [31:0] p;
    p = 32'(a) * 32'(b);
    return p[23:8];
  endfunction

  task automatic refModel(input logic signed [15:0] x0, y0, u0, dx, a,
                          output logic signed [15:0] yRes, output int nRes);
    logic signed [15:0] x, y, u, xn, un, yn;
    bit c;
    x = x0; y = y0; u = u0; nRes = 0;
    do begin
      xn = x + dx;
      un = u - mulq(mulq(mulq(16'sh0300, x), u), dx) - mulq(mulq(16'sh0300, y), dx);
      yn = y + mulq(u, dx);
      c  = (xn < a);
      x = xn; u = un; y = yn;
      nRes++;
    end while (c && nRes < 5000);
    yRes = y;
  endtask

  // one full run; busyStart pulses start with other operands mid-run
  task automatic runCase(input string name, input logic signed [15:0] x0, y0, u0, dx, a,
                         input bit busyStart);
    logic signed [15:0] expY;
    int expN, cyc;
    refModel(x0, y0, u0, dx, a, expY, expN);
    @(negedge clk);
    xIn = x0; yIn = y0; uIn = u0; dxIn = dx; aIn = a; start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(!ready, "R2", {name, " ready after accept"}, 32'(ready), 0);
    cyc = 1;
    while (!done && cyc < 20000) begin
      if (busyStart && cyc == 3) begin
        xIn = 16'sh0100; yIn = 16'sh0555; uIn = 16'sh0222; dxIn = 16'sh0001; start = 1'b1;
      end else begin
        start = 1'b0;
      end
      @(posedge clk);
      @(negedge clk);
      if (!done) cyc++;
    end
    start = 1'b0;
    if (busyStart)
      check(yOut == expY, "R2", {name, " busy start ignored, yOut"}, 32'(yOut), 32'(expY));
    check(yOut == expY, "R3", {name, " yOut"}, 32'(yOut), 32'(expY));
    check(int'(iterCount) == expN, "R4", {name, " iterCount"}, 32'(iterCount), 32'(expN));
    check(cyc == 7 * expN, "R6", {name, " cycles to done"}, 32'(cyc), 32'(7 * expN));
    @(negedge clk);
    check(!done && ready, "R7", {name, " done one cycle then idle"}, {30'd0, done, ready}, 32'd1);
    repeat (5) @(negedge clk);
    check(yOut == expY && int'(iterCount) == expN, "R7", {name, " result held"},
          32'(yOut), 32'(expY));
  endtask

  task automatic oneStepCase(input string name, input logic signed [15:0] x0, y0, u0, dx, a);
    logic signed [15:0] expY;
    expY = y0 + mulq(u0, dx);
    runCase(name, x0, y0, u0, dx, a, 1'b0);
    check(iterCount == 16'd1, "R5", {name, " single step count"}, 32'(iterCount), 1);
    check(yOut == expY, "R5", {name, " single step y"}, 32'(yOut), 32'(expY));
  endtask

  task automatic restartCase();
    logic signed [15:0] prevY;
    logic [15:0] prevN;
    bit sawDone;
    prevY = yOut;
    prevN = iterCount;
    @(negedge clk);
    xIn = 16'sh0000; yIn = 16'sh0100; uIn = 16'sh0000; dxIn = 16'sh0010; aIn = 16'sh0100;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    restart = 1'b1;
    @(negedge clk);
    restart = 1'b0;
    check(ready && !done, "R8", "idle after restart", {30'd0, ready, done}, 32'd2);
    sawDone = 1'b0;
    repeat (200) begin
      @(negedge clk);
      if (done) sawDone = 1'b1;
    end
    check(!sawDone, "R8", "no done from aborted run", 32'(sawDone), 0);
    check(yOut == prevY, "R8", "yOut kept after restart", 32'(yOut), 32'(prevY));
    check(iterCount <= 16'd2, "R8", "aborted run stopped stepping", 32'(iterCount), 2);
    if (prevN == 16'hFFFF) check(0, "R8", "unused", 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(ready && !done && yOut == 0 && iterCount == 0, "R1", "state during reset",
          {14'd0, ready, done, yOut}, 32'h20000);
    rstN = 1'b1;
    @(negedge clk);
    check(ready && !done && yOut == 0 && iterCount == 0, "R1", "state after reset",
          {14'd0, ready, done, yOut}, 32'h20000);

    runCase("decay",      16'sh0000, 16'sh0100, 16'sh0000, 16'sh0010, 16'sh0080, 1'b0);
    runCase("wide step",  16'sh0000, 16'sh0100, 16'sh0040, 16'sh0020, 16'sh0100, 1'b0);
    runCase("negative x", -16'sh0100, 16'sh0080, -16'sh0020, 16'sh0040, 16'sh0000, 1'b0);
    runCase("wraparound", 16'sh0000, 16'sh7000, 16'sh4000, 16'sh0100, 16'sh0200, 1'b0);
    runCase("busy start", 16'sh0000, 16'sh0100, 16'sh0030, 16'sh0018, 16'sh00C0, 1'b1);
    oneStepCase("bound below x", 16'sh0100, 16'sh0200, 16'sh0050, 16'sh0008, 16'sh0080);
    oneStepCase("bound equal x", 16'sh0100, -16'sh0200, 16'sh0123, 16'sh0004, 16'sh0100);
    restartCase();
    runCase("after restart", 16'sh0000, 16'sh0100, 16'sh0000, 16'sh0020, 16'sh0060, 1'b0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule